// File: doc/BRIEF.md
# Transmit FIR Pre-Emphasis Equalizer

This block shapes the drive level of a serial transmitter so that it cancels part of the intersymbol interference of a lossy channel. It accepts one data bit per unit interval, which a clock-enable strobe marks. Each bit becomes a signed symbol: a 1 gives +1 and a 0 gives -1. The symbol enters a short history line with one-UI spacing. Every tap multiplies its symbol by a programmable signed coefficient. The tap results are added, and the sum is clipped to the signed range of the driver code, which gives one output word per unit interval.

There is one tap ahead of the cursor, so the cursor of a bit reaches the output one unit interval after that bit is presented. A typical setting is a de-emphasis profile: a strong cursor and small negative postcursor weights. Runs of equal bits are then driven below full swing, and transitions keep the full level. Coefficients can be written in any cycle, but they are applied only when a unit interval advances. The output register changes only at those edges.

Top module: `txFirEmphasis`

## Requirements
- R1: While reset is asserted, driveLevel is 0 and driveValid is 0. Every history stage holds symbol -1. The coefficients reset to cursor = 64 (1.0 with 6 fractional bits), and the precursor and both postcursors reset to 0.
- R2: When symEn is low, driveLevel and driveValid keep their values and the history does not move, whatever dataBit does.
- R3: At each symEn edge, driveLevel is updated to the following sum. The precursor coefficient multiplies the symbol of the bit presented at that edge. The cursor coefficient multiplies the previous bit, postcursor 1 the bit before that, and postcursor 2 the bit before that again. A bit of 1 counts as +1 and a bit of 0 counts as -1.
- R4: Start from a long run of zeros and present a single 1. The output then departs from the steady level for exactly four consecutive unit intervals, in this order: precursor, cursor, first postcursor, second postcursor. Each of those outputs is ±(sum of coefficients) with the sign of the tap carrying the 1 inverted.
- R5: driveValid rises at the second symEn edge after reset, which is the first edge at which the cursor stage holds a real bit. It then stays high until reset.
- R6: The sum is saturated to the signed 10-bit range [-512, 511]. With all four coefficients at -128 and all symbols at -1, the output is 511.
- R7: A write with coefWrEn stores coefWrData (signed, 6 fractional bits) into the tap selected by coefWrSel: 0 is the precursor, 1 the cursor, 2 postcursor 1 and 3 postcursor 2. Output sums computed at symEn edges strictly after the write cycle use the new value. A write in the same cycle as symEn takes effect from the following symEn edge. A write never changes driveLevel between edges.
- R8: The output is registered. The result of a symEn edge is visible from the cycle after that edge until the next symEn edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| symEn | input | 1 | Unit-interval strobe; one bit is taken per strobe |
| dataBit | input | 1 | Data bit for the current unit interval |
| coefWrEn | input | 1 | Coefficient write strobe |
| coefWrSel | input | 2 | Tap index to write (0 pre, 1 cursor, 2 post1, 3 post2) |
| coefWrData | input | 8 | Signed coefficient, 6 fractional bits |
| driveLevel | output | 10 | Signed, saturated drive code |
| driveValid | output | 1 | High once the cursor stage has filled |

## Verification
The bench builds the block with its default parameters: one precursor tap, two postcursor taps, 8-bit coefficients and a 10-bit output. With 8-bit coefficients, extreme values of -128 and +127 are reachable. The positive clip edge is hit exactly (512 clipped to 511) and the negative end reaches -512 unclipped. One precursor tap makes the one-UI cursor delay and the second-edge valid rule observable. Irregular strobe gaps, and writes that land both between strobes and on a strobe cycle, show that coefficient changes are applied only at unit-interval edges.

// File: rtl/txFirPkg.sv
package txFirPkg;
  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic shift;      // advance one unit interval
    logic coefWr;     // store a coefficient
    logic markValid;  // this advance fills the cursor stage
  } ctrlStrobes_t;
endpackage

// File: rtl/txFirCtrl.sv
module txFirCtrl
  import txFirPkg::*;
#(
  parameter int PRE_TAPS = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         symEn,
  input  logic         coefWrEn,
  output ctrlStrobes_t strobes,
  output logic         driveValid
);
  localparam int CntW = $clog2(PRE_TAPS + 2);
  localparam logic [CntW-1:0] FillDone = CntW'(PRE_TAPS);

  logic [CntW-1:0] fillCnt;
  logic            validQ;

  always_comb begin
    strobes.shift     = symEn;
    strobes.coefWr    = coefWrEn;
    strobes.markValid = symEn && (fillCnt == FillDone);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillCnt <= '0;
      validQ  <= 1'b0;
    end else begin
      if (symEn && fillCnt != FillDone) fillCnt <= fillCnt + 1'b1;
      if (strobes.markValid) validQ <= 1'b1;
    end
  end

  assign driveValid = validQ;
endmodule

// File: rtl/txFirDatapath.sv
module txFirDatapath
  import txFirPkg::*;
#(
  parameter int PRE_TAPS  = 1,
  parameter int POST_TAPS = 2,
  parameter int COEF_W    = 8,
  parameter int COEF_FRAC = 6,
  parameter int OUT_W     = 10
) (
  input  logic                                         clk,
  input  logic                                         rstN,
  input  ctrlStrobes_t                                 strobes,
  input  logic                                         dataBit,
  input  logic [$clog2(PRE_TAPS+POST_TAPS+1)-1:0]      coefWrSel,
  input  logic [COEF_W-1:0]                            coefWrData,
  output logic signed [OUT_W-1:0]                      driveLevel
);
  localparam int NumTaps = PRE_TAPS + POST_TAPS + 1;
  localparam int HistLen = NumTaps - 1;
  localparam int SelW    = $clog2(NumTaps);
  localparam int SumW    = COEF_W + 1 + $clog2(NumTaps);
  localparam int SatHi   = 2 ** (OUT_W - 1) - 1;
  localparam int SatLo   = -(2 ** (OUT_W - 1));

  logic [HistLen-1:0]            histQ;    // bit 0 = most recent past bit
  logic [NumTaps-1:0]            tapBit;   // index 0 = precursor
  logic signed [COEF_W-1:0]      coefQ  [NumTaps];
  logic signed [SumW-1:0]        termW  [NumTaps];
  logic signed [SumW-1:0]        sumAll;
  logic signed [OUT_W-1:0]       satVal;

  assign tapBit = {histQ, dataBit};

  always_ff @(posedge clk) begin
    if (!rstN) histQ <= '0;               // symbol -1 everywhere
    else if (strobes.shift) histQ <= tapBit[HistLen-1:0];
  end

  for (genvar i = 0; i < NumTaps; i++) begin : g_tap
    localparam logic [COEF_W-1:0] ResetCoef =
      (i == PRE_TAPS) ? COEF_W'(1) << COEF_FRAC : '0;
    logic signed [SumW-1:0] coefExt;

    always_ff @(posedge clk) begin
      if (!rstN) coefQ[i] <= ResetCoef;
      else if (strobes.coefWr && coefWrSel == SelW'(i)) coefQ[i] <= coefWrData;
    end

    assign coefExt  = SumW'(coefQ[i]);
    assign termW[i] = tapBit[i] ? coefExt : -coefExt;
  end

  always_comb begin
    sumAll = '0;
    for (int i = 0; i < NumTaps; i++) sumAll = sumAll + termW[i];
    if (sumAll > $signed(SumW'(SatHi)))      satVal = OUT_W'(SatHi);
    else if (sumAll < $signed(SumW'(SatLo))) satVal = OUT_W'(SatLo);
    else                                     satVal = sumAll[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) driveLevel <= '0;
    else if (strobes.shift) driveLevel <= satVal;
  end
endmodule

// File: rtl/txFirEmphasis.sv
module txFirEmphasis
  import txFirPkg::*;
#(
  parameter int PRE_TAPS  = 1,
  parameter int POST_TAPS = 2,
  parameter int COEF_W    = 8,
  parameter int COEF_FRAC = 6,
  parameter int OUT_W     = 10
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  logic                                    symEn,
  input  logic                                    dataBit,
  input  logic                                    coefWrEn,
  input  logic [$clog2(PRE_TAPS+POST_TAPS+1)-1:0] coefWrSel,
  input  logic [COEF_W-1:0]                       coefWrData,
  output logic signed [OUT_W-1:0]                 driveLevel,
  output logic                                    driveValid
);
  ctrlStrobes_t strobes;

  txFirCtrl #(.PRE_TAPS(PRE_TAPS)) u_ctrl (
    .clk(clk), .rstN(rstN), .symEn(symEn), .coefWrEn(coefWrEn),
    .strobes(strobes), .driveValid(driveValid)
  );

  txFirDatapath #(
    .PRE_TAPS(PRE_TAPS), .POST_TAPS(POST_TAPS), .COEF_W(COEF_W),
    .COEF_FRAC(COEF_FRAC), .OUT_W(OUT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dataBit(dataBit),
    .coefWrSel(coefWrSel), .coefWrData(coefWrData), .driveLevel(driveLevel)
  );
endmodule

// File: rtl/txFirEmphasisChecker.sv
module txFirEmphasisChecker #(
  parameter int OUT_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             symEn,
  input logic             coefWrEn,
  input logic [OUT_W-1:0] driveLevel,
  input logic             driveValid
);
  assert_hold_between_ui_R2: assert property (@(posedge clk) disable iff (!rstN)
    !symEn |=> $stable(driveLevel) && $stable(driveValid));

  assert_write_no_glitch_R7: assert property (@(posedge clk) disable iff (!rstN)
    (coefWrEn && !symEn) |=> $stable(driveLevel));

  assert_valid_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    driveValid |=> driveValid);

  assert_valid_on_edge_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(driveValid) |-> $past(symEn));
endmodule

bind txFirEmphasis txFirEmphasisChecker #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rstN(rstN), .symEn(symEn), .coefWrEn(coefWrEn),
  .driveLevel(driveLevel), .driveValid(driveValid)
);

// File: tb/txFirEmphasis_test.sv
module txFirEmphasis_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       symEn = 1'b0;
  logic       dataBit = 1'b0;
  logic       coefWrEn = 1'b0;
  logic [1:0] coefWrSel = '0;
  logic [7:0] coefWrData = '0;
  logic signed [9:0] driveLevel;
  logic       driveValid;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  txFirEmphasis uut (
    .clk(clk), .rstN(rstN), .symEn(symEn), .dataBit(dataBit),
    .coefWrEn(coefWrEn), .coefWrSel(coefWrSel), .coefWrData(coefWrData),
    .driveLevel(driveLevel), .driveValid(driveValid)
  );

  // Behavioural reference model
  int mCoef[4];
  int mHist[$];     // front = most recent past symbol
  int mEdges;
  int expDrive;
  bit expValid;

  always @(posedge clk) begin
    if (!rstN) begin
      mCoef = '{0, 64, 0, 0};
      mHist = '{-1, -1, -1};
      mEdges = 0;
      expDrive = 0;
      expValid = 0;
    end else begin
      if (symEn) begin
        int s;
        int cur;
        cur = dataBit ? 1 : -1;
        s = mCoef[0] * cur + mCoef[1] * mHist[0] + mCoef[2] * mHist[1]
          + mCoef[3] * mHist[2];
        if (s > 511) s = 511;
        if (s < -512) s = -512;
        expDrive = s;
        mHist.push_front(cur);
        void'(mHist.pop_back());
        mEdges++;
        if (mEdges >= 2) expValid = 1;
      end
      if (coefWrEn) mCoef[coefWrSel] = (coefWrData > 127) ? int'(coefWrData) - 256 : int'(coefWrData);
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model (R3, R5)
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R3 model", int'(driveLevel), expDrive);
      check("R5 model", int'(driveValid), int'(expValid));
    end
  end

  task automatic ui(input logic b);
    dataBit = b; symEn = 1'b1;
    @(negedge clk);
    symEn = 1'b0;
  endtask

  task automatic wr(input int sel, input int val);
    coefWrEn = 1'b1; coefWrSel = 2'(sel); coefWrData = 8'(val);
    @(negedge clk);
    coefWrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      dataBit = ~dataBit;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 drive reset", int'(driveLevel), 0);
    check("R1 valid reset", int'(driveValid), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R5/R8: first edge uses cursor=-1 from reset, second edge fills cursor
    ui(1'b1);
    check("R1 reset cursor symbol", int'(driveLevel), -64);
    check("R5 not valid after first edge", int'(driveValid), 0);
    ui(1'b0);
    check("R8 cursor one UI late", int'(driveLevel), 64);
    check("R5 valid after second edge", int'(driveValid), 1);

    // R2: no strobe, output held
    idle(3);
    check("R2 hold", int'(driveLevel), 64);

    // R7: writes between strobes do not disturb output
    wr(0, -6); wr(1, 48); wr(2, -13); wr(3, -3);
    check("R7 no change before edge", int'(driveLevel), 64);

    // R3: steady zeros
    repeat (4) ui(1'b0);
    check("R3 steady zeros", int'(driveLevel), -26);

    // R4: isolated pulse
    ui(1'b1); check("R4 precursor", int'(driveLevel), -38);
    ui(1'b0); check("R4 cursor", int'(driveLevel), 70);
    ui(1'b0); check("R4 post1", int'(driveLevel), -52);
    ui(1'b0); check("R4 post2", int'(driveLevel), -32);
    ui(1'b0); check("R4 settle", int'(driveLevel), -26);

    // R7: write on a strobe cycle applies from the next edge
    coefWrEn = 1'b1; coefWrSel = 2'd0; coefWrData = 8'd20;
    ui(1'b0);
    coefWrEn = 1'b0;
    check("R7 same-cycle write old value", int'(driveLevel), -26);
    ui(1'b0);
    check("R7 same-cycle write next edge", int'(driveLevel), -52);

    // R6: saturation
    wr(0, -128); wr(1, -128); wr(2, -128); wr(3, -128);
    repeat (4) ui(1'b0);
    check("R6 positive clip", int'(driveLevel), 511);
    repeat (4) ui(1'b1);
    check("R6 negative end", int'(driveLevel), -512);
    wr(0, 127); wr(1, 127); wr(2, 127); wr(3, 127);
    ui(1'b1);
    check("R6 no clip high", int'(driveLevel), 508);
    repeat (4) ui(1'b0);
    check("R6 no clip low", int'(driveLevel), -508);

    // Mixed traffic compared against the model every cycle (R3, R7)
    for (int i = 0; i < 400; i++) begin
      symEn    = ($urandom % 3) != 0;
      dataBit  = 1'($urandom);
      coefWrEn = ($urandom % 5) == 0;
      coefWrSel = 2'($urandom);
      coefWrData = 8'($urandom);
      @(negedge clk);
    end
    symEn = 1'b0; coefWrEn = 1'b0;
    @(negedge clk);

    // R1: reset again clears output and valid
    rstN = 1'b0;
    @(negedge clk);
    check("R1 re-reset drive", int'(driveLevel), 0);
    check("R1 re-reset valid", int'(driveValid), 0);
    finish_run();
  end
endmodule